// File: doc/BRIEF.md
# Hierarchical TLB lookup controller

This block translates virtual addresses for two requesters, an instruction fetch side and a data access side. Each side owns a small micro TLB that is consulted first. A miss there falls through to one main TLB shared by both sides, which is searched in the following cycle. Only when the main TLB also misses does the block raise a request to an external page table walker. The walker's answer refills the main TLB and the micro TLB of the side that asked. A main TLB hit refills only the micro TLB of the side that asked.

Every entry records a two-bit size code next to its virtual page tag. Four mapping sizes are supported: 4 KB and 16 KB pages, and 1 MB and 16 MB sections. The tag compare ignores the virtual page bits that fall inside the mapping. A section is resolved by the walker from a single table level, while a page takes two levels. That difference is hidden behind the walker handshake, and this block sees only the returned frame and size code. Each side has a valid/ready request port. It returns a physical address or holds a stall flag while a miss is being resolved. A flush input invalidates every entry in all three TLBs.

Top module: `xlat_hier_ctrl`

## Requirements
- R1: After reset both request ports are ready, no response is valid, both stall flags are low and no walk is requested.
- R2: A request that hits its side's micro TLB produces `rsp_valid` with the physical address in the cycle after acceptance. It raises no walk and leaves the port ready.
- R3: A request that misses its micro TLB but hits the main TLB responds two cycles after acceptance. It refills the micro TLB, so a repeat of the same page answers one cycle after acceptance.
- R4: A walk is requested only when both the micro and the main TLB miss. The walker result answers the request and fills both the main TLB and the requesting side's micro TLB, so a repeat of the page raises no further walk.
- R5: `walk_rsp_size` codes are 0 = 4 KB, 1 = 16 KB, 2 = 1 MB section, 3 = 16 MB section. The low 0, 2, 8 or 12 bits of the virtual page number (address bits 12 and up) are taken from the request address, not from the frame. A later address anywhere in the same mapping hits. The physical address is the masked frame concatenated with the 12-bit page offset.
- R6: The main TLB is shared: a mapping brought in by one side's walk is found by the other side as a main TLB hit.
- R7: From the cycle after a missing request is accepted until its response, that side's `stall` is high and its `req_ready` is low.
- R8: When both sides need the main TLB in the same cycle, the data side is served first. When both need the walker while it is free, the data side's walk is issued first.
- R9: Each TLB replaces entries with its own round-robin victim pointer, so a micro TLB with N entries keeps only the last N pages it was filled with, and the main TLB likewise.
- R10: A one-cycle `flush` pulse invalidates every entry in all TLBs, so the next access to a previously mapped page raises a walk.
- R11: Once raised, `walk_req_valid` stays high with `walk_req_va` unchanged until the cycle in which `walk_rsp_valid` is high. `walk_rsp_valid` is only meaningful while `walk_req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all TLB entries |
| i_req_valid | input | 1 | Instruction side request valid |
| i_req_ready | output | 1 | Instruction side can accept a request |
| i_req_va | input | 32 | Instruction side virtual address |
| i_rsp_valid | output | 1 | Instruction side translation valid, one cycle |
| i_rsp_pa | output | 32 | Instruction side physical address |
| i_stall | output | 1 | Instruction side miss pending |
| d_req_valid | input | 1 | Data side request valid |
| d_req_ready | output | 1 | Data side can accept a request |
| d_req_va | input | 32 | Data side virtual address |
| d_rsp_valid | output | 1 | Data side translation valid, one cycle |
| d_rsp_pa | output | 32 | Data side physical address |
| d_stall | output | 1 | Data side miss pending |
| walk_req_valid | output | 1 | Page table walk requested |
| walk_req_va | output | 32 | Address to be walked |
| walk_rsp_valid | input | 1 | Walk result valid |
| walk_rsp_ppn | input | 20 | Frame number returned by the walk |
| walk_rsp_size | input | 2 | Mapping size code returned by the walk |

## Verification
The hardest situation to reach is both sides contending in the same cycle: one contest is for the main TLB, the other is for a free walker. Both need micro misses that line up exactly and main TLB contents that are known in advance. The bench first builds a known history through a table of vectors, which leaves the data micro TLB and the shared main TLB in a state computed by hand. It then launches both requests on the same clock edge. It checks the response latencies and the order of walk addresses seen by the walker model. Round-robin eviction is reached with a run of distinct pages long enough to wrap both pointers. After that, the first page must walk again, while a later page must come back from the main TLB.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = 20;
    localparam int PA_W  = PPN_W + OFF_W;

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_16K = 2'd1,
        SZ_1M  = 2'd2,
        SZ_16M = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        pg_size_e         size;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_MAIN = 2'd1,
        PS_WALK = 2'd2,
        PS_WAIT = 2'd3
    } port_st_e;

    typedef enum logic [1:0] {
        WO_NONE = 2'd0,
        WO_INST = 2'd1,
        WO_DATA = 2'd2
    } walk_own_e;

    typedef struct packed {
        port_st_e        st;
        logic [VA_W-1:0] va;
        logic            rsp_v;
        logic [PA_W-1:0] pa;
    } port_reg_t;

    // Page-number bits that lie inside a mapping of the given size
    function automatic logic [11:0] low_mask(pg_size_e sz);
        case (sz)
            SZ_4K:   return 12'h000;
            SZ_16K:  return 12'h003;
            SZ_1M:   return 12'h0FF;
            default: return 12'hFFF;
        endcase
    endfunction

    // Frame for one 4 KB granule: upper bits from the entry, inner bits from the address
    function automatic logic [PPN_W-1:0] merge_ppn(logic [PPN_W-1:0] ppn,
                                                    logic [VPN_W-1:0] vpn,
                                                    pg_size_e sz);
        logic [PPN_W-1:0] m;
        m = PPN_W'(low_mask(sz));
        return (ppn & ~m) | (PPN_W'(vpn) & m);
    endfunction
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output pg_size_e         lk_size,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  pg_size_e         fill_size
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ent;
        logic     [IDX_W-1:0]   rr;
    } tlb_reg_t;

    tlb_reg_t state_d, state_q;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] vld_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign vld_vec[g] = state_q.ent[g].vld;
        assign hit_vec[g] = state_q.ent[g].vld &&
            (((state_q.ent[g].vpn ^ lk_vpn) &
              ~VPN_W'(low_mask(state_q.ent[g].size))) == '0);
    end

    // Lowest matching index wins
    always_comb begin
        tlb_ent_t sel;
        sel = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (hit_vec[k]) sel = state_q.ent[k];
        end
        lk_hit  = |hit_vec;
        lk_ppn  = merge_ppn(sel.ppn, lk_vpn, sel.size);
        lk_size = sel.size;
    end

    always_comb begin
        state_d = state_q;
        if (flush) begin
            for (int k = 0; k < ENTRIES; k++) state_d.ent[k].vld = 1'b0;
        end else if (fill_en) begin
            state_d.ent[state_q.rr].vld  = 1'b1;
            state_d.ent[state_q.rr].vpn  = fill_vpn;
            state_d.ent[state_q.rr].ppn  = fill_ppn;
            state_d.ent[state_q.rr].size = fill_size;
            state_d.rr = (state_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : state_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_vec == '0));

    assert_fill_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> vld_vec[$past(state_q.rr)]);
endmodule

// File: rtl/xlat_port.sv
module xlat_port
    import xlat_pkg::*;
#(
    parameter int MICRO_ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             stall,
    output logic             want_main,
    input  logic             main_grant,
    input  logic             main_hit,
    input  logic [PPN_W-1:0] main_ppn,
    input  pg_size_e         main_size,
    output logic             want_walk,
    input  logic             walk_grant,
    input  logic             walk_done,
    input  logic [PPN_W-1:0] walk_ppn,
    input  pg_size_e         walk_size,
    output logic [VA_W-1:0]  pend_va
);
    port_reg_t state_d, state_q;

    logic [VPN_W-1:0] u_vpn;
    logic             u_hit;
    logic [PPN_W-1:0] u_ppn;
    pg_size_e         u_size;
    logic             u_fill;
    logic [PPN_W-1:0] u_fill_ppn;
    pg_size_e         u_fill_size;
    logic [PPN_W-1:0] walk_frame;

    assign u_vpn      = (state_q.st == PS_IDLE) ? req_va[VA_W-1:OFF_W] : state_q.va[VA_W-1:OFF_W];
    assign walk_frame = merge_ppn(walk_ppn, state_q.va[VA_W-1:OFF_W], walk_size);

    xlat_tlb #(.ENTRIES(MICRO_ENTRIES)) u_micro (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_vpn    (u_vpn),
        .lk_hit    (u_hit),
        .lk_ppn    (u_ppn),
        .lk_size   (u_size),
        .fill_en   (u_fill),
        .fill_vpn  (state_q.va[VA_W-1:OFF_W]),
        .fill_ppn  (u_fill_ppn),
        .fill_size (u_fill_size)
    );

    always_comb begin
        state_d       = state_q;
        state_d.rsp_v = 1'b0;
        u_fill        = 1'b0;
        u_fill_ppn    = main_ppn;
        u_fill_size   = main_size;
        case (state_q.st)
            PS_IDLE: begin
                if (req_valid) begin
                    if (u_hit) begin
                        state_d.rsp_v = 1'b1;
                        state_d.pa    = {u_ppn, req_va[OFF_W-1:0]};
                    end else begin
                        state_d.st = PS_MAIN;
                        state_d.va = req_va;
                    end
                end
            end
            PS_MAIN: begin
                if (main_grant) begin
                    if (main_hit) begin
                        u_fill        = 1'b1;
                        state_d.rsp_v = 1'b1;
                        state_d.pa    = {main_ppn, state_q.va[OFF_W-1:0]};
                        state_d.st    = PS_IDLE;
                    end else begin
                        state_d.st = PS_WALK;
                    end
                end
            end
            PS_WALK: begin
                if (walk_grant) state_d.st = PS_WAIT;
            end
            default: begin
                if (walk_done) begin
                    u_fill        = 1'b1;
                    u_fill_ppn    = walk_frame;
                    u_fill_size   = walk_size;
                    state_d.rsp_v = 1'b1;
                    state_d.pa    = {walk_frame, state_q.va[OFF_W-1:0]};
                    state_d.st    = PS_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign req_ready = (state_q.st == PS_IDLE);
    assign stall     = (state_q.st != PS_IDLE);
    assign want_main = (state_q.st == PS_MAIN);
    assign want_walk = (state_q.st == PS_WALK);
    assign rsp_valid = state_q.rsp_v;
    assign rsp_pa    = state_q.pa;
    assign pend_va   = state_q.va;

    assert_micro_hit_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && u_hit) |=> (rsp_valid && req_ready));

    assert_miss_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !u_hit) |=> (stall && !rsp_valid));

    assert_main_hit_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (want_main && main_grant && main_hit) |=> (rsp_valid && req_ready));

    assert_walk_done_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == PS_WAIT && walk_done) |=> (rsp_valid && !stall));
endmodule

// File: rtl/xlat_hier_ctrl.sv
module xlat_hier_ctrl
    import xlat_pkg::*;
#(
    parameter int MICRO_ENTRIES = 4,
    parameter int MAIN_ENTRIES  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        i_req_valid,
    output logic        i_req_ready,
    input  logic [31:0] i_req_va,
    output logic        i_rsp_valid,
    output logic [31:0] i_rsp_pa,
    output logic        i_stall,
    input  logic        d_req_valid,
    output logic        d_req_ready,
    input  logic [31:0] d_req_va,
    output logic        d_rsp_valid,
    output logic [31:0] d_rsp_pa,
    output logic        d_stall,
    output logic        walk_req_valid,
    output logic [31:0] walk_req_va,
    input  logic        walk_rsp_valid,
    input  logic [19:0] walk_rsp_ppn,
    input  logic [1:0]  walk_rsp_size
);
    typedef struct packed {
        walk_own_e own;
    } top_reg_t;

    top_reg_t state_d, state_q;

    logic             i_want_main, d_want_main, i_want_walk, d_want_walk;
    logic             i_main_grant, d_main_grant;
    logic             i_walk_grant, d_walk_grant;
    logic             i_walk_done, d_walk_done;
    logic [VA_W-1:0]  i_pend_va, d_pend_va;
    logic [VPN_W-1:0] m_vpn;
    logic             m_hit;
    logic [PPN_W-1:0] m_ppn;
    pg_size_e         m_size;
    logic             m_fill;
    logic [VPN_W-1:0] m_fill_vpn;
    pg_size_e         rsp_size;

    assign rsp_size = pg_size_e'(walk_rsp_size);

    // Main TLB arbitration: data side first
    assign d_main_grant = d_want_main;
    assign i_main_grant = i_want_main && !d_want_main;
    assign m_vpn        = d_want_main ? d_pend_va[VA_W-1:OFF_W] : i_pend_va[VA_W-1:OFF_W];

    // Walker arbitration: data side first, one walk at a time
    assign d_walk_grant = (state_q.own == WO_NONE) && d_want_walk;
    assign i_walk_grant = (state_q.own == WO_NONE) && !d_want_walk && i_want_walk;
    assign d_walk_done  = (state_q.own == WO_DATA) && walk_rsp_valid;
    assign i_walk_done  = (state_q.own == WO_INST) && walk_rsp_valid;

    assign walk_req_valid = (state_q.own != WO_NONE);
    assign walk_req_va    = (state_q.own == WO_DATA) ? d_pend_va : i_pend_va;
    assign m_fill         = walk_req_valid && walk_rsp_valid;
    assign m_fill_vpn     = walk_req_va[VA_W-1:OFF_W];

    always_comb begin
        state_d = state_q;
        if (state_q.own == WO_NONE) begin
            if (d_want_walk)      state_d.own = WO_DATA;
            else if (i_want_walk) state_d.own = WO_INST;
        end else if (walk_rsp_valid) begin
            state_d.own = WO_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    xlat_tlb #(.ENTRIES(MAIN_ENTRIES)) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_vpn    (m_vpn),
        .lk_hit    (m_hit),
        .lk_ppn    (m_ppn),
        .lk_size   (m_size),
        .fill_en   (m_fill),
        .fill_vpn  (m_fill_vpn),
        .fill_ppn  (walk_rsp_ppn),
        .fill_size (rsp_size)
    );

    xlat_port #(.MICRO_ENTRIES(MICRO_ENTRIES)) u_iport (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .req_valid  (i_req_valid),
        .req_ready  (i_req_ready),
        .req_va     (i_req_va),
        .rsp_valid  (i_rsp_valid),
        .rsp_pa     (i_rsp_pa),
        .stall      (i_stall),
        .want_main  (i_want_main),
        .main_grant (i_main_grant),
        .main_hit   (m_hit),
        .main_ppn   (m_ppn),
        .main_size  (m_size),
        .want_walk  (i_want_walk),
        .walk_grant (i_walk_grant),
        .walk_done  (i_walk_done),
        .walk_ppn   (walk_rsp_ppn),
        .walk_size  (rsp_size),
        .pend_va    (i_pend_va)
    );

    xlat_port #(.MICRO_ENTRIES(MICRO_ENTRIES)) u_dport (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .req_valid  (d_req_valid),
        .req_ready  (d_req_ready),
        .req_va     (d_req_va),
        .rsp_valid  (d_rsp_valid),
        .rsp_pa     (d_rsp_pa),
        .stall      (d_stall),
        .want_main  (d_want_main),
        .main_grant (d_main_grant),
        .main_hit   (m_hit),
        .main_ppn   (m_ppn),
        .main_size  (m_size),
        .want_walk  (d_want_walk),
        .walk_grant (d_walk_grant),
        .walk_done  (d_walk_done),
        .walk_ppn   (walk_rsp_ppn),
        .walk_size  (rsp_size),
        .pend_va    (d_pend_va)
    );

    assert_main_data_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        d_want_main |-> !i_main_grant);

    assert_walk_data_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.own == WO_NONE && d_want_walk && i_want_walk) |=>
        (walk_req_valid && walk_req_va == $past(d_pend_va)));

    assert_walk_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_va)));

    assert_walk_only_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_req_valid) |-> $past(!m_hit && (d_want_main || i_want_main)) || $past(d_want_walk || i_want_walk));
endmodule

// File: tb/tb_xlat_hier_ctrl.sv
module tb_xlat_hier_ctrl;
    localparam int WLAT = 3;
    localparam int NVEC = 14;
    localparam logic [19:0] FKEY = 20'h35A3C;
    // {side(1=data), va, kind(0=micro hit,1=main hit,2=walk)}
    localparam logic [34:0] VEC [0:NVEC-1] = '{
        {1'b1, 32'h0000_1234, 2'd2},
        {1'b1, 32'h0000_1FF0, 2'd0},
        {1'b0, 32'h0000_1008, 2'd1},
        {1'b0, 32'h0000_1000, 2'd0},
        {1'b1, 32'h4000_2345, 2'd2},
        {1'b1, 32'h4000_3111, 2'd0},
        {1'b1, 32'h4000_4000, 2'd2},
        {1'b0, 32'h8010_0000, 2'd2},
        {1'b0, 32'h801F_F004, 2'd0},
        {1'b1, 32'hC100_0000, 2'd2},
        {1'b1, 32'hC1AB_CDEF, 2'd0},
        {1'b1, 32'hC200_0000, 2'd2},
        {1'b1, 32'h0000_1000, 2'd1},
        {1'b1, 32'h0000_1004, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        i_req_valid = 1'b0, d_req_valid = 1'b0;
    logic [31:0] i_req_va = '0, d_req_va = '0;
    logic        i_req_ready, d_req_ready, i_rsp_valid, d_rsp_valid, i_stall, d_stall;
    logic [31:0] i_rsp_pa, d_rsp_pa;
    logic        walk_req_valid;
    logic [31:0] walk_req_va;
    logic        walk_rsp_valid = 1'b0;
    logic [19:0] walk_rsp_ppn = '0;
    logic [1:0]  walk_rsp_size = '0;

    int checks = 0;
    int errors = 0;
    int walk_cnt = 0;
    logic [31:0] walk_log [0:63];

    always #4 clk = ~clk;

    xlat_hier_ctrl dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .i_req_valid(i_req_valid), .i_req_ready(i_req_ready), .i_req_va(i_req_va),
        .i_rsp_valid(i_rsp_valid), .i_rsp_pa(i_rsp_pa), .i_stall(i_stall),
        .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_req_va(d_req_va),
        .d_rsp_valid(d_rsp_valid), .d_rsp_pa(d_rsp_pa), .d_stall(d_stall),
        .walk_req_valid(walk_req_valid), .walk_req_va(walk_req_va),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn),
        .walk_rsp_size(walk_rsp_size)
    );

    function automatic logic [19:0] size_bits(logic [1:0] sz);
        case (sz)
            2'd0: return 20'h00000;
            2'd1: return 20'h00003;
            2'd2: return 20'h000FF;
            default: return 20'h00FFF;
        endcase
    endfunction

    // Page table model: size from address bits 31:30, frame from a fixed key
    function automatic logic [31:0] exp_pa(logic [31:0] va);
        logic [19:0] vpn, m;
        vpn = va[31:12];
        m = size_bits(va[31:30]);
        return {((vpn ^ FKEY) & ~m) | (vpn & m), va[11:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Walker model: answers each request after WLAT cycles, unmasked frame
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && walk_req_valid) begin
                if (walk_cnt < 64) walk_log[walk_cnt] = walk_req_va;
                walk_cnt++;
                repeat (WLAT) @(negedge clk);
                walk_rsp_ppn   = walk_req_va[31:12] ^ FKEY;
                walk_rsp_size  = walk_req_va[31:30];
                walk_rsp_valid = 1'b1;
                @(negedge clk);
                walk_rsp_valid = 1'b0;
            end
        end
    end

    task automatic issue(input bit side, input logic [31:0] va,
                         output logic [31:0] pa, output int lat);
        @(negedge clk);
        if (side) begin d_req_valid = 1'b1; d_req_va = va; end
        else      begin i_req_valid = 1'b1; i_req_va = va; end
        while (!(side ? d_req_ready : i_req_ready)) @(negedge clk);
        @(negedge clk);
        if (side) d_req_valid = 1'b0; else i_req_valid = 1'b0;
        lat = 1;
        while (!(side ? d_rsp_valid : i_rsp_valid)) begin
            @(negedge clk);
            lat++;
        end
        pa = side ? d_rsp_pa : i_rsp_pa;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic run_one(input bit side, input logic [31:0] va, input int kind, input string req);
        logic [31:0] pa;
        int lat, w0;
        w0 = walk_cnt;
        issue(side, va, pa, lat);
        chk(pa == exp_pa(va), "R5", {req, " physical address"}, pa, exp_pa(va));
        if (kind == 0)
            chk(lat == 1 && walk_cnt == w0, req, "micro hit latency/walks", 32'(lat), 32'd1);
        else if (kind == 1)
            chk(lat == 2 && walk_cnt == w0, req, "main hit latency/walks", 32'(lat), 32'd2);
        else
            chk(lat > 2 && walk_cnt == w0 + 1, req, "walk count", 32'(walk_cnt - w0), 32'd1);
    endtask

    logic [31:0] pa_a, pa_b;
    int lat_a, lat_b, w0;
    logic st_d_seen, st_i_seen, rdy_seen;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(i_req_ready && d_req_ready, "R1", "ready after reset", {30'd0, i_req_ready, d_req_ready}, 32'd3);
        chk(!i_rsp_valid && !d_rsp_valid, "R1", "rsp_valid after reset", {30'd0, i_rsp_valid, d_rsp_valid}, 32'd0);
        chk(!i_stall && !d_stall && !walk_req_valid, "R1", "stall/walk after reset",
            {29'd0, i_stall, d_stall, walk_req_valid}, 32'd0);

        // Vector table: R2 micro hit, R3 main hit, R4 walk, R5 sizes, R6 sharing, R9 micro eviction
        for (int v = 0; v < NVEC; v++) begin
            string rq;
            case (VEC[v][1:0])
                2'd0: rq = "R2";
                2'd1: rq = (v == 12) ? "R9" : (VEC[v][34] ? "R3" : "R6");
                default: rq = "R4";
            endcase
            run_one(VEC[v][34], VEC[v][33:2], int'(VEC[v][1:0]), rq);
        end

        // R8 main TLB priority: both miss micro, both hit main, same edge
        fork
            issue(1'b1, 32'h8012_3456, pa_a, lat_a);
            issue(1'b0, 32'h4000_2000, pa_b, lat_b);
        join
        chk(lat_a == 2, "R8", "data main-hit latency", 32'(lat_a), 32'd2);
        chk(lat_b == 3, "R8", "inst main-hit latency while data served", 32'(lat_b), 32'd3);
        chk(pa_a == exp_pa(32'h8012_3456) && pa_b == exp_pa(32'h4000_2000), "R8", "contended addresses",
            pa_b, exp_pa(32'h4000_2000));

        // R8 walker priority and R7 stall: both miss everywhere on the same edge
        w0 = walk_cnt;
        st_d_seen = 1'b0; st_i_seen = 1'b0; rdy_seen = 1'b1;
        fork
            issue(1'b1, 32'h1234_5000, pa_a, lat_a);
            issue(1'b0, 32'h0567_8000, pa_b, lat_b);
            begin
                @(negedge clk);
                repeat (2) @(negedge clk);
                st_d_seen = d_stall; st_i_seen = i_stall; rdy_seen = d_req_ready | i_req_ready;
            end
        join
        chk(st_d_seen && st_i_seen && !rdy_seen, "R7", "stall high, ready low while pending",
            {29'd0, st_d_seen, st_i_seen, rdy_seen}, 32'd6);
        chk(walk_cnt == w0 + 2, "R8", "two walks", 32'(walk_cnt - w0), 32'd2);
        chk(walk_log[w0] == 32'h1234_5000, "R8", "data walk first", walk_log[w0], 32'h1234_5000);
        chk(walk_log[w0 + 1] == 32'h0567_8000, "R11", "inst walk address held", walk_log[w0 + 1], 32'h0567_8000);
        chk(pa_a == exp_pa(32'h1234_5000) && pa_b == exp_pa(32'h0567_8000), "R4", "walked addresses",
            pa_a, exp_pa(32'h1234_5000));
        chk(lat_b > lat_a, "R8", "inst finishes after data", 32'(lat_b), 32'(lat_a));

        // R10 flush
        pulse_flush();
        run_one(1'b1, 32'h0000_1000, 2, "R10");
        run_one(1'b0, 32'h8010_0000, 2, "R10");

        // R9 round robin across both levels: nine distinct pages
        pulse_flush();
        for (int k = 0; k < 9; k++) run_one(1'b1, 32'h0100_0000 + 32'(k) * 32'h1000, 2, "R9");
        run_one(1'b1, 32'h0100_0000, 2, "R9");
        run_one(1'b1, 32'h0100_2000, 1, "R9");
        run_one(1'b1, 32'h0100_8000, 0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule